// File: doc/BRIEF.md
# Peripheral Bus Access Filter

This block sits in front of a group of bus peripherals and decides, for each incoming request, whether that request may reach its target. A request names a peripheral index, a 3-bit compartment ID (CID) and a secure attribute. The verdict draws on three things. The first is a per-peripheral security bit. The second is a per-peripheral CID configuration word. The third is a live ownership report from an external semaphore bank that says which CID currently holds each peripheral.

Each peripheral works in one of two modes. In semaphore mode the programmed static CID plays no part. A request passes only when its CID is on the peripheral's whitelist and that same CID holds the semaphore. In static mode the request CID must match the programmed CID. A static CID of 0 matches every requester, and so does a disabled filter. A set security bit blocks every non-secure request, whatever the CID outcome.

Configuration goes through a simple write-strobe and combinational-read port. That port also carries a read-only register that reports three entry counts. Their sum is the number of peripherals, and an index at or above that sum is refused. The grant is combinational. Every refused request also raises a one-cycle registered deny pulse.

Top module: `paf_top`

## Requirements
- R1: After reset every register reads 0 and deny_pulse is 0. With that configuration, any request to an index below the peripheral count is granted whatever its CID and secure attribute.
- R2: Security bits live at byte address 0x010 + 4*(n/32), bit n%32, for peripheral n. Privilege bits use the same layout from 0x030. Both read back what was written, and bits of peripherals that do not exist read 0.
- R3: Peripheral n has a CID word at 0x100 + 8*n. Its fields are filter enable in bit 0, semaphore mode in bit 1, static CID in bits 6:4, and a whitelist in bits 23:16 with bit 16+c for CID c. All other bits read 0 (the readback mask is 0x00FF0073).
- R4: Address 0xFEC always reads {count_c[7:0], count_b[7:0], count_a[15:0]}, which is 0x02060020 with the defaults, and writes to it have no effect.
- R5: A request whose index is at or above count_a + count_b + count_c is denied.
- R6: When a peripheral's filter enable is 0, every CID passes the CID check.
- R7: When filter enable is 1, semaphore mode is 0 and the static CID is 0, every CID passes the CID check.
- R8: When filter enable is 1, semaphore mode is 0 and the static CID is non-zero, only a request whose CID equals the static CID passes.
- R9: When filter enable and semaphore mode are both 1, the static CID is ignored. The CID check passes only if the request CID's whitelist bit is set, sem_held[n] is 1 and sem_owner[3n+2:3n] equals the request CID.
- R10: When peripheral n's security bit is 1, a request with req_secure = 0 is denied, whatever the CID check gives. Secure requests are not affected.
- R11: req_grant follows the request inputs in the same cycle and is 0 while req_valid is 0. deny_pulse is 1 in the cycle after a valid request that was not granted, and 0 after any other cycle.
- R12: Privilege bits are stored only and have no effect on req_grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational from cfg_addr |
| req_valid | input | 1 | Request present |
| req_idx | input | IDX_W (6) | Target peripheral index |
| req_cid | input | 3 | Requester compartment ID |
| req_secure | input | 1 | Request is secure |
| sem_held | input | N (40) | Per-peripheral: semaphore currently taken |
| sem_owner | input | 3*N (120) | Per-peripheral CID of the semaphore holder, 3 bits each |
| req_grant | output | 1 | Request allowed (combinational) |
| deny_pulse | output | 1 | Registered one-cycle pulse after a refused request |

## Verification
The grant and the read data have no register in their path. The bench therefore drives each request or address half a period before a rising edge and samples 1 ns later, in the same cycle. The deny pulse passes through exactly one flop, so the bench samples it at the following falling edge, one rising edge after the request. The request is held until then. A configuration write lands on the rising edge that follows the strobe, so readback and any request that depends on it come at the next falling edge or later.

// File: rtl/paf_pkg.sv
package paf_pkg;

    localparam int CID_W  = 3;
    localparam int NCID   = 1 << CID_W;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] SEC_BASE   = 12'h010;
    localparam logic [ADDR_W-1:0] PRIV_BASE  = 12'h030;
    localparam logic [ADDR_W-1:0] CIDW_BASE  = 12'h100;
    localparam logic [ADDR_W-1:0] HWCFG_ADDR = 12'hFEC;

    typedef logic [CID_W-1:0] cid_t;

    // Stored per-peripheral CID configuration
    typedef struct packed {
        logic [NCID-1:0] wlist;
        cid_t            scid;
        logic            sem_en;
        logic            flt_en;
    } cidcfg_t;

    function automatic cidcfg_t word_to_cfg(input logic [DATA_W-1:0] w);
        cidcfg_t c;
        c.flt_en = w[0];
        c.sem_en = w[1];
        c.scid   = w[6:4];
        c.wlist  = w[16 +: NCID];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input cidcfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0]          = c.flt_en;
        w[1]          = c.sem_en;
        w[6:4]        = c.scid;
        w[16 +: NCID] = c.wlist;
        return w;
    endfunction

    // CID part of the verdict for one peripheral
    function automatic logic cid_pass(input cidcfg_t c, input cid_t rc,
                                      input logic held, input cid_t owner);
        if (c.flt_en && c.sem_en)
            return c.wlist[rc] && held && (owner == rc);
        return !c.flt_en || (c.scid == '0) || (c.scid == rc);
    endfunction

endpackage

// File: rtl/paf_regs.sv
module paf_regs
    import paf_pkg::*;
#(
    parameter int N     = 40,
    parameter int CNT_A = 32,
    parameter int CNT_B = 6,
    parameter int CNT_C = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [N-1:0]       sec_o,
    output cidcfg_t [N-1:0]    cfg_o
);

    localparam logic [DATA_W-1:0] HWCFG =
        {8'(CNT_C), 8'(CNT_B), 16'(CNT_A)};

    logic [N-1:0]    sec_q;
    logic [N-1:0]    priv_q;
    cidcfg_t [N-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q  <= '0;
            priv_q <= '0;
            cfg_q  <= '0;
        end else if (wr) begin
            for (int n = 0; n < N; n++) begin
                if (addr == 12'(SEC_BASE + 12'(4 * (n / 32))))
                    sec_q[n] <= wdata[n % 32];
                if (addr == 12'(PRIV_BASE + 12'(4 * (n / 32))))
                    priv_q[n] <= wdata[n % 32];
                if (addr == 12'(CIDW_BASE + 12'(8 * n)))
                    cfg_q[n] <= word_to_cfg(wdata);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == HWCFG_ADDR)
            rdata = HWCFG;
        for (int n = 0; n < N; n++) begin
            if (addr == 12'(SEC_BASE + 12'(4 * (n / 32))))
                rdata[n % 32] = sec_q[n];
            if (addr == 12'(PRIV_BASE + 12'(4 * (n / 32))))
                rdata[n % 32] = priv_q[n];
            if (addr == 12'(CIDW_BASE + 12'(8 * n)))
                rdata = cfg_to_word(cfg_q[n]);
        end
    end

    assign sec_o = sec_q;
    assign cfg_o = cfg_q;

endmodule

// File: rtl/paf_decide.sv
module paf_decide
    import paf_pkg::*;
#(
    parameter int N     = 40,
    parameter int IDX_W = 6
) (
    input  logic             valid,
    input  logic [IDX_W-1:0] idx,
    input  cid_t             cid,
    input  logic             secure,
    input  logic [N-1:0]     sec,
    input  cidcfg_t [N-1:0]  cfg,
    input  logic [N-1:0]     held,
    input  logic [CID_W*N-1:0] owner,
    output logic             allow
);

    logic    hit;
    logic    sel_sec;
    logic    sel_held;
    cid_t    sel_owner;
    cidcfg_t sel_cfg;

    // One-hot select of the addressed peripheral; no hit means out of range
    always_comb begin
        hit       = 1'b0;
        sel_sec   = 1'b0;
        sel_held  = 1'b0;
        sel_owner = '0;
        sel_cfg   = '0;
        for (int n = 0; n < N; n++) begin
            if (idx == IDX_W'(n)) begin
                hit       = 1'b1;
                sel_sec   = sec[n];
                sel_held  = held[n];
                sel_owner = owner[CID_W*n +: CID_W];
                sel_cfg   = cfg[n];
            end
        end
    end

    assign allow = valid && hit
                && cid_pass(sel_cfg, cid, sel_held, sel_owner)
                && (!sel_sec || secure);

endmodule

// File: rtl/paf_top.sv
module paf_top
    import paf_pkg::*;
#(
    parameter int CNT_A = 32,
    parameter int CNT_B = 6,
    parameter int CNT_C = 2,
    parameter int N     = CNT_A + CNT_B + CNT_C,
    parameter int IDX_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic                 req_valid,
    input  logic [IDX_W-1:0]     req_idx,
    input  logic [CID_W-1:0]     req_cid,
    input  logic                 req_secure,
    input  logic [N-1:0]         sem_held,
    input  logic [CID_W*N-1:0]   sem_owner,
    output logic                 req_grant,
    output logic                 deny_pulse
);

    logic [N-1:0]    sec_vec;
    cidcfg_t [N-1:0] cfg_vec;
    logic            allow;
    logic            deny_q;

    paf_regs #(.N(N), .CNT_A(CNT_A), .CNT_B(CNT_B), .CNT_C(CNT_C)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .sec_o (sec_vec),
        .cfg_o (cfg_vec)
    );

    paf_decide #(.N(N), .IDX_W(IDX_W)) u_decide (
        .valid  (req_valid),
        .idx    (req_idx),
        .cid    (req_cid),
        .secure (req_secure),
        .sec    (sec_vec),
        .cfg    (cfg_vec),
        .held   (sem_held),
        .owner  (sem_owner),
        .allow  (allow)
    );

    always_ff @(posedge clk) begin
        if (rst) deny_q <= 1'b0;
        else     deny_q <= req_valid && !allow;
    end

    assign req_grant  = allow;
    assign deny_pulse = deny_q;

endmodule

// File: rtl/paf_chk.sv
module paf_chk #(
    parameter int          N     = 40,
    parameter int          IDX_W = 6,
    parameter logic [31:0] HW    = 32'h0
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_idx,
    input logic             req_secure,
    input logic             req_grant,
    input logic             deny_pulse,
    input logic [11:0]      cfg_addr,
    input logic [31:0]      cfg_rdata,
    input logic [N-1:0]     sec_vec
);

    logic sec_hit;
    always_comb begin
        sec_hit = 1'b0;
        for (int n = 0; n < N; n++)
            if (req_idx == IDX_W'(n)) sec_hit = sec_vec[n];
    end

    AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !req_grant); // R11
    AST_DENY_AFTER_REFUSAL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_grant) |=> deny_pulse); // R11
    AST_NO_SPURIOUS_DENY: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_grant) |=> !deny_pulse); // R11
    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(req_idx) >= N) |-> !req_grant); // R5
    AST_SECURE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_secure && sec_hit) |-> !req_grant); // R10
    AST_HWCFG_CONST: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == 12'hFEC) |-> (cfg_rdata == HW)); // R4

endmodule

bind paf_top paf_chk #(
    .N     (N),
    .IDX_W (IDX_W),
    .HW    ({8'(CNT_C), 8'(CNT_B), 16'(CNT_A)})
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_idx    (req_idx),
    .req_secure (req_secure),
    .req_grant  (req_grant),
    .deny_pulse (deny_pulse),
    .cfg_addr   (cfg_addr),
    .cfg_rdata  (cfg_rdata),
    .sec_vec    (sec_vec)
);

// File: tb/test_paf_top.sv
module test_paf_top;

    localparam int N = 40;
    localparam int IDX_W = 6;
    localparam logic [31:0] WMASK = 32'h00FF0073;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [11:0]   cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          req_valid = 1'b0;
    logic [5:0]    req_idx = '0;
    logic [2:0]    req_cid = '0;
    logic          req_secure = 1'b0;
    logic [N-1:0]  sem_held = '0;
    logic [3*N-1:0] sem_owner = '0;
    logic          req_grant;
    logic          deny_pulse;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    logic [31:0]  sh_word [N];
    logic [N-1:0] sh_sec;

    always #10 clk = ~clk;

    paf_top i_paf_top (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_idx(req_idx), .req_cid(req_cid), .req_secure(req_secure),
        .sem_held(sem_held), .sem_owner(sem_owner),
        .req_grant(req_grant), .deny_pulse(deny_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit model(input int idx, input logic [2:0] c, input bit s);
        logic [31:0] w;
        bit pass;
        if (idx >= N) return 0;
        w = sh_word[idx];
        if (w[0] && w[1])
            pass = w[16 + c] && sem_held[idx] && (sem_owner[idx*3 +: 3] == c);
        else
            pass = !w[0] || (w[6:4] == 3'd0) || (w[6:4] == c);
        return pass && (!sh_sec[idx] || s);
    endfunction

    // Called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wr_cid(input int n, input logic [31:0] d);
        wr(12'(12'h100 + 8*n), d);
        sh_word[n] = d & WMASK;
    endtask

    task automatic wr_sec(input int r, input logic [31:0] d);
        wr(12'(12'h010 + 4*r), d);
        for (int n = 32*r; n < 32*r + 32 && n < N; n++) sh_sec[n] = d[n % 32];
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    // Grant checked in the same cycle, deny pulse one rising edge later
    task automatic req(input string tag, input int idx, input logic [2:0] c, input bit s);
        bit e;
        e = model(idx, c, s);
        req_valid = 1'b1; req_idx = 6'(idx); req_cid = c; req_secure = s;
        #1;
        chk({tag, " grant"}, {31'd0, req_grant}, {31'd0, e});
        @(negedge clk);
        chk({tag, " deny_pulse"}, {31'd0, deny_pulse}, {31'd0, !e});
        req_valid = 1'b0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int n = 0; n < N; n++) sh_word[n] = '0;
        sh_sec = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 deny after reset", {31'd0, deny_pulse}, 32'd0);
        rd("R1 sec reset", 12'h010, 32'd0);
        rd("R1 priv reset", 12'h034, 32'd0);
        rd("R1 cid word reset", 12'h100, 32'd0);
        req("R1 open access", 5, 3'd3, 1'b0);
        req("R1 open access last", 39, 3'd7, 1'b0);

        // R4 hardware configuration register
        rd("R4 hwcfg", 12'hFEC, 32'h02060020);
        wr(12'hFEC, 32'hFFFF_FFFF);
        rd("R4 hwcfg after write", 12'hFEC, 32'h02060020);

        // R2 security / privilege layout
        wr_sec(1, 32'hFFFF_FFFF);
        rd("R2 sec reg1 unused bits", 12'h014, 32'h0000_00FF);
        wr_sec(0, 32'hA5A5_A5A5);
        rd("R2 sec reg0", 12'h010, 32'hA5A5_A5A5);
        wr(12'h030, 32'h1234_5678);
        rd("R2 priv reg0", 12'h030, 32'h1234_5678);

        // R10 security bit
        req("R10 nonsecure blocked", 0, 3'd1, 1'b0);
        req("R10 secure allowed", 0, 3'd1, 1'b1);
        req("R10 clear bit nonsecure", 1, 3'd1, 1'b0);
        req("R10 high reg bit", 35, 3'd0, 1'b0);

        // R12 privilege bits have no effect
        wr(12'h030, 32'hFFFF_FFFF);
        req("R12 priv ignored", 1, 3'd5, 1'b0);
        wr_sec(0, 32'h0);
        wr_sec(1, 32'h0);

        // R3 CID word layout
        wr_cid(3, 32'hFFFF_FFFF);
        rd("R3 cid word mask", 12'h118, 32'h00FF_0073);
        rd("R3 neighbour untouched", 12'h120, 32'd0);

        // R6 filter off
        wr_cid(4, 32'h0000_0050);
        req("R6 filter off any cid", 4, 3'd2, 1'b0);
        // R7 static CID zero is wildcard
        wr_cid(4, 32'h0000_0001);
        req("R7 wildcard", 4, 3'd6, 1'b0);
        // R8 static CID match
        wr_cid(4, 32'h0000_0051);
        req("R8 match", 4, 3'd5, 1'b0);
        req("R8 mismatch", 4, 3'd4, 1'b0);

        // R9 semaphore mode
        wr_cid(4, 32'h0004_0053);
        sem_held[4] = 1'b1; sem_owner[12 +: 3] = 3'd2;
        req("R9 owner whitelisted", 4, 3'd2, 1'b0);
        req("R9 static cid ignored", 4, 3'd5, 1'b0);
        sem_owner[12 +: 3] = 3'd3;
        req("R9 other owner", 4, 3'd2, 1'b0);
        req("R9 owner not whitelisted", 4, 3'd3, 1'b0);
        sem_owner[12 +: 3] = 3'd2; sem_held[4] = 1'b0;
        req("R9 semaphore free", 4, 3'd2, 1'b0);

        // R5 index range
        req("R5 first out of range", 40, 3'd0, 1'b1);
        req("R5 top index", 63, 3'd0, 1'b1);

        // R11 no valid, no grant, no pulse
        req_idx = 6'd1; #1;
        chk("R11 idle grant", {31'd0, req_grant}, 32'd0);
        @(negedge clk);
        chk("R11 idle deny", {31'd0, deny_pulse}, 32'd0);

        // Random mix across R5..R10
        for (int it = 0; it < 400; it++) begin
            int n;
            int idx;
            logic [31:0] w;
            logic [2:0] c;
            n = int'($urandom % N);
            w = $urandom;
            if ($urandom % 2 == 0) w[6:4] = 3'($urandom % 2);
            if ($urandom % 3 == 0) wr_cid(n, w);
            if ($urandom % 8 == 0) wr_sec(int'($urandom % 2), $urandom);
            idx = ($urandom % 4 == 0) ? int'($urandom % 64) : n;
            c = 3'($urandom);
            for (int k = 0; k < N; k++) begin
                sem_held[k] = 1'($urandom);
                sem_owner[3*k +: 3] = ($urandom % 2 == 0) ? c : 3'($urandom);
            end
            req("R9 R8 R10 R5 random", idx, c, 1'($urandom));
        end

        summary();
    end

endmodule